// File: doc/BRIEF.md
# Transaction Error Monitor Logger

This block sits on the response side of one initiator port of an on-chip fabric. Each time the fabric reports a failed transaction, it gives the block a one-cycle strobe with a 3-bit kind code, the 64-bit address and the attributes of that transaction. The block keeps one sticky status bit per error kind. It keeps a second sticky bit per kind that records a repeat of that kind before software cleared it. It also keeps a snapshot of the first failing transaction since the last clear, packed into readable 32-bit log words.

Software reaches the block through a simple register port. The port has an address, a write strobe, write data and combinational read data. The block drives a level to the interrupt notifier that stays high while any status bit is set. Software reads the log, then writes ones to the status register to clear the kinds it has handled. Writing ones to the overflow register clears the repeat markers.

Top module: `txn_err_monitor`

## Requirements
- R1: An event strobe with kind code k from 0 to 5 sets status bit k, readable at offset 0x208 from the cycle after the strobe. The kind codes in order are: 0 target error, 1 decode miss, 2 firewall block, 3 response timeout, 4 powered-down region, 5 unsupported access.
- R2: An event strobe with kind code 6 or 7 changes no status, overflow or log register.
- R3: An event of kind k that arrives while status bit k is already set sets overflow bit k, readable at offset 0x20C.
- R4: Writing to 0x208 clears each status bit whose write-data bit is one, so 0x3F clears all six. If a clear and a new event of the same kind fall in the same cycle, the bit ends up set.
- R5: Writing to 0x20C clears each overflow bit whose write-data bit is one. A repeat in the same cycle wins over the clear.
- R6: If the logger holds nothing, an event of a valid kind is captured. Offset 0x304 then reads address bits [31:0] and offset 0x308 reads bits [63:32].
- R7: Log word 0 at 0x30C holds cache bits in [27:24], protection in [22:20], burst length in [19:12], burst type in [9:8], beat size in [6:4] and the write flag in [0]. All other bits read zero.
- R8: Log word 1 at 0x310 holds the 8-bit access ID in [7:0]. Log word 2 at 0x314 holds the target ID in [7:0], the fabric ID in [20:16] and the requester socket ID in [27:24]. All other bits read zero.
- R9: Log word 3 at 0x318 holds the security level in [1:0], the group-security field in [14:8], the queue class in [17:16] and the initiator ID in [29:24]. All other bits read zero.
- R10: While the logger holds an entry, later events leave every log word unchanged. The logger status at 0x300 is the one-hot bit of the logged kind. It clears when a status write clears that kind's bit, and the next valid event is then captured, including one in the same cycle as that clear.
- R11: The pending output is high exactly when at least one status bit is set.
- R12: After reset every register reads zero and pending is low. Offsets other than the nine above read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | Error event strobe, one cycle per event |
| evt_kind | input | 3 | Error kind code |
| evt_addr | input | 64 | Address of the failing transaction |
| evt_cache | input | 4 | Cache attribute bits |
| evt_prot | input | 3 | Protection attribute bits |
| evt_burst_len | input | 8 | Burst length |
| evt_burst_type | input | 2 | Burst type |
| evt_beat_size | input | 3 | Beat size |
| evt_write | input | 1 | 1 for a write, 0 for a read |
| evt_access_id | input | 8 | Transaction access ID |
| evt_fabric_id | input | 5 | Fabric ID |
| evt_target_id | input | 8 | Target ID |
| evt_socket_id | input | 4 | Requester socket ID |
| evt_initiator_id | input | 6 | Initiator ID |
| evt_queue_class | input | 2 | Queue class |
| evt_group_sec | input | 7 | Group-security field |
| evt_sec_level | input | 2 | Security level |
| reg_addr | input | 12 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| err_pending | output | 1 | High while any status bit is set |

## Verification
A wrong status or overflow bit shows at the port on the next read of 0x208 or 0x20C, one cycle after the event that caused it. A wrong status bit also shows on err_pending in that same cycle. A logger that captures at the wrong time is different. It shows only as a changed address or attribute word on a later read, so the bench reads the whole map after every burst of random events and clears. Directed cases place a clear and an event in the same cycle, and send codes 6 and 7, so that priority and filtering mistakes reach the read port within one cycle.

// File: rtl/tem_pkg.sv
package tem_pkg;

  localparam int OFF_STATUS   = 12'h208;
  localparam int OFF_OVERFLOW = 12'h20C;
  localparam int OFF_LOGSTS   = 12'h300;
  localparam int OFF_ADDR_LO  = 12'h304;
  localparam int OFF_ADDR_HI  = 12'h308;
  localparam int OFF_WORD0    = 12'h30C;
  localparam int OFF_WORD1    = 12'h310;
  localparam int OFF_WORD2    = 12'h314;
  localparam int OFF_WORD3    = 12'h318;

  typedef struct packed {
    logic [3:0] cache;
    logic [2:0] prot;
    logic [7:0] blen;
    logic [1:0] btype;
    logic [2:0] beat;
    logic       wr;
    logic [7:0] acc_id;
    logic [4:0] fab_id;
    logic [7:0] tgt_id;
    logic [3:0] sock_id;
    logic [5:0] init_id;
    logic [1:0] qclass;
    logic [6:0] grp_sec;
    logic [1:0] sec_lvl;
  } txn_attr_t;

  function automatic logic [31:0] pack_xfer(input txn_attr_t a);
    logic [31:0] w;
    w        = '0;
    w[27:24] = a.cache;
    w[22:20] = a.prot;
    w[19:12] = a.blen;
    w[9:8]   = a.btype;
    w[6:4]   = a.beat;
    w[0]     = a.wr;
    return w;
  endfunction

  function automatic logic [31:0] pack_ident(input txn_attr_t a);
    logic [31:0] w;
    w       = '0;
    w[7:0]  = a.acc_id;
    return w;
  endfunction

  function automatic logic [31:0] pack_route(input txn_attr_t a);
    logic [31:0] w;
    w        = '0;
    w[27:24] = a.sock_id;
    w[20:16] = a.fab_id;
    w[7:0]   = a.tgt_id;
    return w;
  endfunction

  function automatic logic [31:0] pack_origin(input txn_attr_t a);
    logic [31:0] w;
    w        = '0;
    w[29:24] = a.init_id;
    w[17:16] = a.qclass;
    w[14:8]  = a.grp_sec;
    w[1:0]   = a.sec_lvl;
    return w;
  endfunction

endpackage

// File: rtl/tem_kind_tracker.sv
module tem_kind_tracker #(
  parameter int KIND_W    = 3,
  parameter int NUM_KINDS = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 evt_valid,
  input  logic [KIND_W-1:0]    evt_kind,
  input  logic [NUM_KINDS-1:0] sts_clr,
  input  logic [NUM_KINDS-1:0] ovf_clr,
  output logic [NUM_KINDS-1:0] hit,
  output logic [NUM_KINDS-1:0] status,
  output logic [NUM_KINDS-1:0] overflow
);

  logic [NUM_KINDS-1:0] status_nxt;
  logic [NUM_KINDS-1:0] overflow_nxt;
  logic                 sts_en;
  logic                 ovf_en;

  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
    assign hit[k] = evt_valid && (evt_kind == KIND_W'(k));

    p_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
      hit[k] |=> status[k]);

    p_repeat_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[k] && status[k]) |=> overflow[k]);

    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_clr[k] && !hit[k]) |=> !status[k]);

    p_ovfclr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_clr[k] && !(hit[k] && status[k])) |=> !overflow[k]);
  end

  always_comb begin
    status_nxt   = (status & ~sts_clr) | hit;
    overflow_nxt = (overflow & ~ovf_clr) | (hit & status);
    sts_en       = (|hit) || (|sts_clr);
    ovf_en       = (|(hit & status)) || (|ovf_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
    end else if (sts_en) begin
      status <= status_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      overflow <= '0;
    end else if (ovf_en) begin
      overflow <= overflow_nxt;
    end
  end

  p_filter_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && (int'(evt_kind) >= NUM_KINDS)) |-> (hit == '0));

endmodule

// File: rtl/tem_log_capture.sv
module tem_log_capture
  import tem_pkg::*;
#(
  parameter int NUM_KINDS = 6,
  parameter int LOG_AW    = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_KINDS-1:0] hit,
  input  logic [NUM_KINDS-1:0] sts_clr,
  input  logic [LOG_AW-1:0]    evt_addr,
  input  txn_attr_t            evt_attr,
  output logic [NUM_KINDS-1:0] log_sts,
  output logic [LOG_AW-1:0]    addr_q,
  output logic [31:0]          xfer_q,
  output logic [31:0]          ident_q,
  output logic [31:0]          route_q,
  output logic [31:0]          origin_q
);

  logic [NUM_KINDS-1:0] kept;
  logic [NUM_KINDS-1:0] log_sts_nxt;
  logic                 capture;
  logic                 lsts_en;

  always_comb begin
    kept        = log_sts & ~sts_clr;
    capture     = (kept == '0) && (|hit);
    log_sts_nxt = capture ? hit : kept;
    lsts_en     = capture || (|(log_sts & sts_clr));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      log_sts <= '0;
    end else if (lsts_en) begin
      log_sts <= log_sts_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      xfer_q   <= '0;
      ident_q  <= '0;
      route_q  <= '0;
      origin_q <= '0;
    end else if (capture) begin
      addr_q   <= evt_addr;
      xfer_q   <= pack_xfer(evt_attr);
      ident_q  <= pack_ident(evt_attr);
      route_q  <= pack_route(evt_attr);
      origin_q <= pack_origin(evt_attr);
    end
  end

  p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(log_sts));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((log_sts != '0) && ((log_sts & sts_clr) == '0))
      |=> ($stable(addr_q) && $stable(xfer_q) && $stable(origin_q)));

  p_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((log_sts == '0) && (hit != '0)) |=> (log_sts == $past(hit)));

endmodule

// File: rtl/tem_reg_port.sv
module tem_reg_port
  import tem_pkg::*;
#(
  parameter int NUM_KINDS = 6,
  parameter int LOG_AW    = 64,
  parameter int REG_AW    = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [REG_AW-1:0]    reg_addr,
  input  logic                 reg_wr,
  input  logic [31:0]          reg_wdata,
  input  logic [NUM_KINDS-1:0] status,
  input  logic [NUM_KINDS-1:0] overflow,
  input  logic [NUM_KINDS-1:0] log_sts,
  input  logic [LOG_AW-1:0]    addr_q,
  input  logic [31:0]          xfer_q,
  input  logic [31:0]          ident_q,
  input  logic [31:0]          route_q,
  input  logic [31:0]          origin_q,
  output logic [NUM_KINDS-1:0] sts_clr,
  output logic [NUM_KINDS-1:0] ovf_clr,
  output logic [31:0]          reg_rdata
);

  logic [63:0] addr_wide;
  logic        unused_wbits;

  assign addr_wide    = 64'(addr_q);
  assign unused_wbits = ^reg_wdata[31:NUM_KINDS];

  always_comb begin
    sts_clr = '0;
    ovf_clr = '0;
    if (reg_wr && (reg_addr == REG_AW'(OFF_STATUS))) begin
      sts_clr = reg_wdata[NUM_KINDS-1:0];
    end
    if (reg_wr && (reg_addr == REG_AW'(OFF_OVERFLOW))) begin
      ovf_clr = reg_wdata[NUM_KINDS-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      REG_AW'(OFF_STATUS):   reg_rdata = 32'(status);
      REG_AW'(OFF_OVERFLOW): reg_rdata = 32'(overflow);
      REG_AW'(OFF_LOGSTS):   reg_rdata = 32'(log_sts);
      REG_AW'(OFF_ADDR_LO):  reg_rdata = addr_wide[31:0];
      REG_AW'(OFF_ADDR_HI):  reg_rdata = addr_wide[63:32];
      REG_AW'(OFF_WORD0):    reg_rdata = xfer_q;
      REG_AW'(OFF_WORD1):    reg_rdata = ident_q;
      REG_AW'(OFF_WORD2):    reg_rdata = route_q;
      REG_AW'(OFF_WORD3):    reg_rdata = origin_q;
      default:               reg_rdata = '0;
    endcase
  end

  p_nowrite_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |-> ((sts_clr == '0) && (ovf_clr == '0)));

endmodule

// File: rtl/txn_err_monitor.sv
module txn_err_monitor
  import tem_pkg::*;
#(
  parameter int KIND_W    = 3,
  parameter int NUM_KINDS = 6,
  parameter int LOG_AW    = 64,
  parameter int REG_AW    = 12,
  parameter int SYNC_LEN  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  input  logic [KIND_W-1:0] evt_kind,
  input  logic [LOG_AW-1:0] evt_addr,
  input  logic [3:0]        evt_cache,
  input  logic [2:0]        evt_prot,
  input  logic [7:0]        evt_burst_len,
  input  logic [1:0]        evt_burst_type,
  input  logic [2:0]        evt_beat_size,
  input  logic              evt_write,
  input  logic [7:0]        evt_access_id,
  input  logic [4:0]        evt_fabric_id,
  input  logic [7:0]        evt_target_id,
  input  logic [3:0]        evt_socket_id,
  input  logic [5:0]        evt_initiator_id,
  input  logic [1:0]        evt_queue_class,
  input  logic [6:0]        evt_group_sec,
  input  logic [1:0]        evt_sec_level,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              err_pending
);

  logic [SYNC_LEN-1:0]  rst_pipe;
  logic                 rst_q_n;
  txn_attr_t            attr;
  logic [NUM_KINDS-1:0] hit;
  logic [NUM_KINDS-1:0] status;
  logic [NUM_KINDS-1:0] overflow;
  logic [NUM_KINDS-1:0] sts_clr;
  logic [NUM_KINDS-1:0] ovf_clr;
  logic [NUM_KINDS-1:0] log_sts;
  logic [LOG_AW-1:0]    addr_q;
  logic [31:0]          xfer_q;
  logic [31:0]          ident_q;
  logic [31:0]          route_q;
  logic [31:0]          origin_q;
  logic                 pend_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[SYNC_LEN-2:0], 1'b1};
    end
  end
  assign rst_q_n = rst_pipe[SYNC_LEN-1];

  always_comb begin
    attr.cache   = evt_cache;
    attr.prot    = evt_prot;
    attr.blen    = evt_burst_len;
    attr.btype   = evt_burst_type;
    attr.beat    = evt_beat_size;
    attr.wr      = evt_write;
    attr.acc_id  = evt_access_id;
    attr.fab_id  = evt_fabric_id;
    attr.tgt_id  = evt_target_id;
    attr.sock_id = evt_socket_id;
    attr.init_id = evt_initiator_id;
    attr.qclass  = evt_queue_class;
    attr.grp_sec = evt_group_sec;
    attr.sec_lvl = evt_sec_level;
  end

  tem_kind_tracker #(.KIND_W(KIND_W), .NUM_KINDS(NUM_KINDS)) u_track (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .evt_valid(evt_valid),
    .evt_kind (evt_kind),
    .sts_clr  (sts_clr),
    .ovf_clr  (ovf_clr),
    .hit      (hit),
    .status   (status),
    .overflow (overflow)
  );

  tem_log_capture #(.NUM_KINDS(NUM_KINDS), .LOG_AW(LOG_AW)) u_log (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .hit     (hit),
    .sts_clr (sts_clr),
    .evt_addr(evt_addr),
    .evt_attr(attr),
    .log_sts (log_sts),
    .addr_q  (addr_q),
    .xfer_q  (xfer_q),
    .ident_q (ident_q),
    .route_q (route_q),
    .origin_q(origin_q)
  );

  tem_reg_port #(.NUM_KINDS(NUM_KINDS), .LOG_AW(LOG_AW), .REG_AW(REG_AW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .reg_addr (reg_addr),
    .reg_wr   (reg_wr),
    .reg_wdata(reg_wdata),
    .status   (status),
    .overflow (overflow),
    .log_sts  (log_sts),
    .addr_q   (addr_q),
    .xfer_q   (xfer_q),
    .ident_q  (ident_q),
    .route_q  (route_q),
    .origin_q (origin_q),
    .sts_clr  (sts_clr),
    .ovf_clr  (ovf_clr),
    .reg_rdata(reg_rdata)
  );

  assign pend_nxt = |((status & ~sts_clr) | hit);

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      err_pending <= 1'b0;
    end else begin
      err_pending <= pend_nxt;
    end
  end

  p_pending_r11: assert property (@(posedge clk) disable iff (!rst_q_n)
    err_pending == (|status));

  p_logsub_r10: assert property (@(posedge clk) disable iff (!rst_q_n)
    (log_sts & ~status) == '0);

endmodule

// File: tb/sim_txn_err_monitor.sv
module sim_txn_err_monitor;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        evt_valid;
  logic [2:0]  evt_kind;
  logic [63:0] evt_addr;
  logic [3:0]  evt_cache;
  logic [2:0]  evt_prot;
  logic [7:0]  evt_burst_len;
  logic [1:0]  evt_burst_type;
  logic [2:0]  evt_beat_size;
  logic        evt_write;
  logic [7:0]  evt_access_id;
  logic [4:0]  evt_fabric_id;
  logic [7:0]  evt_target_id;
  logic [3:0]  evt_socket_id;
  logic [5:0]  evt_initiator_id;
  logic [1:0]  evt_queue_class;
  logic [6:0]  evt_group_sec;
  logic [1:0]  evt_sec_level;
  logic [11:0] reg_addr;
  logic        reg_wr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        err_pending;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [5:0]  m_sts, m_ovf, m_lsts;
  logic [63:0] m_addr;
  logic [31:0] m_w0, m_w1, m_w2, m_w3;

  always #4 clk = ~clk;

  txn_err_monitor u0 (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_kind(evt_kind),
    .evt_addr(evt_addr), .evt_cache(evt_cache), .evt_prot(evt_prot),
    .evt_burst_len(evt_burst_len), .evt_burst_type(evt_burst_type),
    .evt_beat_size(evt_beat_size), .evt_write(evt_write),
    .evt_access_id(evt_access_id), .evt_fabric_id(evt_fabric_id),
    .evt_target_id(evt_target_id), .evt_socket_id(evt_socket_id),
    .evt_initiator_id(evt_initiator_id), .evt_queue_class(evt_queue_class),
    .evt_group_sec(evt_group_sec), .evt_sec_level(evt_sec_level),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .err_pending(err_pending)
  );

  function automatic logic [31:0] exp_w0();
    return {4'b0, evt_cache, 1'b0, evt_prot, evt_burst_len, 2'b0, evt_burst_type,
            1'b0, evt_beat_size, 3'b0, evt_write};
  endfunction
  function automatic logic [31:0] exp_w2();
    return {4'b0, evt_socket_id, 3'b0, evt_fabric_id, 8'b0, evt_target_id};
  endfunction
  function automatic logic [31:0] exp_w3();
    return {2'b0, evt_initiator_id, 6'b0, evt_queue_class, 1'b0, evt_group_sec,
            6'b0, evt_sec_level};
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  // Reference update for the inputs currently driven; takes effect at the next edge.
  task automatic model_step();
    logic [5:0] hitv, sclr, oclr, kept;
    hitv = (evt_valid && evt_kind < 3'd6) ? (6'd1 << evt_kind) : 6'd0;
    sclr = (reg_wr && reg_addr == 12'h208) ? reg_wdata[5:0] : 6'd0;
    oclr = (reg_wr && reg_addr == 12'h20C) ? reg_wdata[5:0] : 6'd0;
    m_ovf = (m_ovf & ~oclr) | (hitv & m_sts);
    kept  = m_lsts & ~sclr;
    if (kept == 6'd0 && hitv != 6'd0) begin
      m_lsts = hitv;
      m_addr = evt_addr;
      m_w0 = exp_w0();
      m_w1 = {24'b0, evt_access_id};
      m_w2 = exp_w2();
      m_w3 = exp_w3();
    end else begin
      m_lsts = kept;
    end
    m_sts = (m_sts & ~sclr) | hitv;
  endtask

  task automatic randomize_fields();
    evt_addr         = {$urandom, $urandom};
    evt_cache        = 4'($urandom);
    evt_prot         = 3'($urandom);
    evt_burst_len    = 8'($urandom);
    evt_burst_type   = 2'($urandom);
    evt_beat_size    = 3'($urandom);
    evt_write        = 1'($urandom);
    evt_access_id    = 8'($urandom);
    evt_fabric_id    = 5'($urandom);
    evt_target_id    = 8'($urandom);
    evt_socket_id    = 4'($urandom);
    evt_initiator_id = 6'($urandom);
    evt_queue_class  = 2'($urandom);
    evt_group_sec    = 7'($urandom);
    evt_sec_level    = 2'($urandom);
  endtask

  // One cycle of stimulus: drive at negedge, update model.
  task automatic cycle(input bit v, input logic [2:0] k, input bit w,
                       input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    evt_valid = v;
    evt_kind  = k;
    randomize_fields();
    reg_wr    = w;
    reg_addr  = a;
    reg_wdata = d;
    model_step();
  endtask

  task automatic idle();
    @(negedge clk);
    evt_valid = 1'b0;
    reg_wr    = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic check_all();
    logic [31:0] v;
    idle();
    rd(12'h208, v); chk("R1 status", v, {26'b0, m_sts});
    rd(12'h20C, v); chk("R3 overflow", v, {26'b0, m_ovf});
    rd(12'h300, v); chk("R10 logger status", v, {26'b0, m_lsts});
    rd(12'h304, v); chk("R6 addr low", v, m_addr[31:0]);
    rd(12'h308, v); chk("R6 addr high", v, m_addr[63:32]);
    rd(12'h30C, v); chk("R7 word0", v, m_w0);
    rd(12'h310, v); chk("R8 word1", v, m_w1);
    rd(12'h314, v); chk("R8 word2", v, m_w2);
    rd(12'h318, v); chk("R9 word3", v, m_w3);
    rd(12'h040, v); chk("R12 unmapped", v, 32'h0);
    chk("R11 pending", {31'b0, err_pending}, {31'b0, |m_sts});
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    evt_valid = 1'b0; evt_kind = '0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    randomize_fields();
    m_sts = '0; m_ovf = '0; m_lsts = '0; m_addr = '0;
    m_w0 = '0; m_w1 = '0; m_w2 = '0; m_w3 = '0;
    repeat (3) @(negedge clk);
    check_all();                       // R12 reset state
    rst_n = 1'b1;
    repeat (4) idle();
    check_all();

    // R2: codes 6 and 7 ignored
    cycle(1'b1, 3'd6, 1'b0, 12'h0, 32'h0);
    cycle(1'b1, 3'd7, 1'b0, 12'h0, 32'h0);
    check_all();

    // R1/R6: first error captured; R10: second kept out of log; R3 repeat
    cycle(1'b1, 3'd3, 1'b0, 12'h0, 32'h0);
    cycle(1'b1, 3'd1, 1'b0, 12'h0, 32'h0);
    cycle(1'b1, 3'd3, 1'b0, 12'h0, 32'h0);
    check_all();

    // R12: write to an unmapped offset has no effect
    cycle(1'b0, 3'd0, 1'b1, 12'h100, 32'hFFFF_FFFF);
    check_all();

    // R4/R10: clear of logged kind with same-cycle new event of that kind
    cycle(1'b1, 3'd3, 1'b1, 12'h208, 32'h0000_0008);
    check_all();

    // R4: clear all with 0x3F, R11 pending drops
    cycle(1'b0, 3'd0, 1'b1, 12'h208, 32'h0000_003F);
    check_all();
    begin
      logic [31:0] v;
      rd(12'h208, v); chk("R4 clear all", v, 32'h0);
    end

    // R5: overflow clear, and repeat wins over clear
    cycle(1'b1, 3'd5, 1'b0, 12'h0, 32'h0);
    cycle(1'b1, 3'd5, 1'b1, 12'h20C, 32'h0000_003F);
    check_all();
    cycle(1'b0, 3'd0, 1'b1, 12'h20C, 32'h0000_003F);
    check_all();

    // Random rounds
    for (int r = 0; r < 40; r++) begin
      for (int c = 0; c < 16; c++) begin
        bit          v, w;
        logic [11:0] a;
        v = ($urandom % 3) != 0;
        w = ($urandom % 6) == 0;
        a = ($urandom % 2) ? 12'h208 : 12'h20C;
        cycle(v, 3'($urandom), w, a, (($urandom % 4) == 0) ? 32'h3F : 32'($urandom));
      end
      check_all();
    end

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule